// File: doc/BRIEF.md
# Generic Address Window Decoder

This block sorts each memory request made through a flat thread address space into one of three target spaces: per-thread local memory, per-workgroup shared memory, or global virtual memory. Two programmable windows, each 16 MB and aligned to 16 MB, select the local and shared regions. Every address outside them is global. The block returns the target space and the offset within it. It also flags atomic or reduction requests aimed at a window, and it flags misaligned accesses.

The window bases are written through a small method-offset/data port, and they can be read back on the same port. A status register keeps the first error code seen until software clears it. Requests arrive on a valid/ready handshake. Each result is registered and leaves on a second valid/ready handshake, one cycle after the request is accepted. Graphics requests have no shared window, so for them the shared region falls through to global.

Top module: `gaw_decoder`

## Requirements
- R1: After reset the local base reads 0xFF000000, the shared base reads 0xFE000000, the status register at offset 0x48 reads 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Two conditions together give space local (code 1) with offset equal to address bits [23:0]: address bits [63:32] are zero, and address bits [31:24] equal the local base bits [31:24].
- R3: An address that matches the shared base in the same way gives space shared (code 2) with offset equal to bits [23:0] when `req_gfx` is 0. When `req_gfx` is 1 the same address decodes as global.
- R4: Any other address decodes as global (code 0) with the offset equal to the full 64-bit address. This includes addresses with nonzero bits [63:32].
- R5: When both bases hold the same value, an address inside that window decodes as local.
- R6: Opcode atomic (2) or reduction (3) that decodes to local or shared returns error 0x10. Load (0), store (1) and cache-control (4) never return 0x10, and neither do atomic or reduction requests on global addresses.
- R7: Opcode direct-local (5) always gives space local and opcode direct-shared (6) always gives space shared. In both cases the offset is address bits [23:0], no window compare is made, and no space error is raised. Direct-shared applies in graphics too.
- R8: With `req_size` taken as log2 of the access bytes (0 to 3), an address whose low bits are not a multiple of the access size returns error 0x0F. This takes priority over 0x10.
- R9: A write to offset 0x77C (local) or 0x214 (shared) whose data bits [23:0] are all zero loads that base. Otherwise the base is left unchanged and status bit 8 (configuration error) is set and stays set.
- R10: Status bits [7:0] capture the first nonzero response error code and keep it while later errors arrive. Any write to offset 0x48 clears bits [7:0] and bit 8.
- R11: `req_ready` equals `!rsp_valid || rsp_ready`. An accepted request produces `rsp_valid` on the next cycle. While `rsp_valid` is high and `rsp_ready` is low, the response fields hold steady.
- R12: `cfg_rdata` presents, one cycle after `cfg_raddr`, the local base (0x77C), the shared base (0x214) or the status register (0x48), and 0 for any other offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_waddr | input | 12 | Method offset of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_raddr | input | 12 | Method offset to read |
| cfg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 64 | Flat address |
| req_op | input | 3 | Opcode class: 0 load, 1 store, 2 atomic, 3 reduction, 4 cache-control, 5 direct-local, 6 direct-shared |
| req_size | input | 2 | log2 of access size in bytes |
| req_gfx | input | 1 | 1 for a graphics shader, 0 for compute |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_space | output | 2 | 0 global, 1 local, 2 shared |
| rsp_offset | output | 64 | Offset within the target space |
| rsp_err | output | 8 | 0 none, 0x0F misaligned, 0x10 invalid space |

## Verification
The assertions take three things for granted. Request fields stay constant while `req_valid` waits for `req_ready`. `req_op` never carries the reserved value 7. No status clear lands in the same cycle as an erroring request. The driver holds every request field from the cycle it raises `req_valid` until it sees the handshake complete, uses only the seven defined opcodes, and clears the status only after the response queue has drained. The response consumer's ready is throttled at random, and in one phase it is held low for several cycles, which exercises the hold and stall behaviour.

// File: rtl/gaw_pkg.sv
package gaw_pkg;
  typedef enum logic [1:0] {
    SP_GLOBAL = 2'd0,
    SP_LOCAL  = 2'd1,
    SP_SHARED = 2'd2
  } space_e;

  localparam logic [2:0] OP_LOAD  = 3'd0;
  localparam logic [2:0] OP_STORE = 3'd1;
  localparam logic [2:0] OP_ATOM  = 3'd2;
  localparam logic [2:0] OP_RED   = 3'd3;
  localparam logic [2:0] OP_CCTL  = 3'd4;
  localparam logic [2:0] OP_LCL   = 3'd5;
  localparam logic [2:0] OP_SHR   = 3'd6;

  localparam logic [7:0] ERR_NONE     = 8'h00;
  localparam logic [7:0] ERR_MISALIGN = 8'h0F;
  localparam logic [7:0] ERR_SPACE    = 8'h10;

  localparam logic [11:0] MTH_LOCAL  = 12'h77C;
  localparam logic [11:0] MTH_SHARED = 12'h214;
  localparam logic [11:0] MTH_STATUS = 12'h048;
endpackage

// File: rtl/gaw_win_regs.sv
module gaw_win_regs
  import gaw_pkg::*;
#(
  parameter int BASE_W = 32,
  parameter int WIN_LOG2 = 24,
  parameter int CFG_AW = 12,
  parameter int ERR_W = 8,
  parameter logic [BASE_W-1:0] LOCAL_RST = 32'hFF00_0000,
  parameter logic [BASE_W-1:0] SHARED_RST = 32'hFE00_0000,
  localparam int TAG_W = BASE_W - WIN_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_waddr,
  input  logic [BASE_W-1:0] cfg_wdata,
  input  logic [CFG_AW-1:0] cfg_raddr,
  output logic [BASE_W-1:0] cfg_rdata,
  input  logic              acc_valid,
  input  logic [ERR_W-1:0]  acc_err,
  output logic [TAG_W-1:0]  loc_tag,
  output logic [TAG_W-1:0]  shr_tag,
  output logic [ERR_W-1:0]  stat_code,
  output logic              cfg_err
);
  localparam logic [CFG_AW-1:0] A_LOC = CFG_AW'(MTH_LOCAL);
  localparam logic [CFG_AW-1:0] A_SHR = CFG_AW'(MTH_SHARED);
  localparam logic [CFG_AW-1:0] A_STS = CFG_AW'(MTH_STATUS);

  logic aligned, wr_loc, wr_shr, wr_sts, new_err;
  assign aligned = (cfg_wdata[WIN_LOG2-1:0] == '0);
  assign wr_loc  = cfg_wr && (cfg_waddr == A_LOC);
  assign wr_shr  = cfg_wr && (cfg_waddr == A_SHR);
  assign wr_sts  = cfg_wr && (cfg_waddr == A_STS);
  assign new_err = acc_valid && (acc_err != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_tag <= LOCAL_RST[BASE_W-1:WIN_LOG2];
      shr_tag <= SHARED_RST[BASE_W-1:WIN_LOG2];
    end else begin
      if (wr_loc && aligned) loc_tag <= cfg_wdata[BASE_W-1:WIN_LOG2];
      if (wr_shr && aligned) shr_tag <= cfg_wdata[BASE_W-1:WIN_LOG2];
    end
  end

  // first error wins; a clear write empties the latch
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_code <= '0;
      cfg_err   <= 1'b0;
    end else begin
      if (wr_sts) stat_code <= new_err ? acc_err : '0;
      else if (new_err && stat_code == '0) stat_code <= acc_err;
      if (wr_sts) cfg_err <= 1'b0;
      else if ((wr_loc || wr_shr) && !aligned) cfg_err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else begin
      case (cfg_raddr)
        A_LOC:   cfg_rdata <= {loc_tag, {WIN_LOG2{1'b0}}};
        A_SHR:   cfg_rdata <= {shr_tag, {WIN_LOG2{1'b0}}};
        A_STS:   cfg_rdata <= BASE_W'({cfg_err, stat_code});
        default: cfg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/gaw_classify.sv
module gaw_classify
  import gaw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int BASE_W = 32,
  parameter int WIN_LOG2 = 24,
  parameter int ERR_W = 8,
  localparam int TAG_W = BASE_W - WIN_LOG2,
  localparam int NWIN = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        op,
  input  logic [1:0]        size,
  input  logic              gfx,
  input  logic [TAG_W-1:0]  loc_tag,
  input  logic [TAG_W-1:0]  shr_tag,
  output space_e            space,
  output logic [ADDR_W-1:0] offset,
  output logic [ERR_W-1:0]  err
);
  logic [NWIN-1:0][TAG_W-1:0] tags;
  logic [NWIN-1:0] win_en, hit;
  logic hi_zero;

  assign tags[0] = loc_tag;
  assign tags[1] = shr_tag;
  assign win_en  = {~gfx, 1'b1};
  assign hi_zero = (addr[ADDR_W-1:BASE_W] == '0);

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign hit[w] = win_en[w] && hi_zero && (addr[BASE_W-1:WIN_LOG2] == tags[w]);
  end

  logic [ADDR_W-1:0] in_win;
  assign in_win = {{(ADDR_W-WIN_LOG2){1'b0}}, addr[WIN_LOG2-1:0]};

  always_comb begin
    if (op == OP_LCL) begin
      space = SP_LOCAL;   offset = in_win;
    end else if (op == OP_SHR) begin
      space = SP_SHARED;  offset = in_win;
    end else if (hit[0]) begin
      space = SP_LOCAL;   offset = in_win;
    end else if (hit[1]) begin
      space = SP_SHARED;  offset = in_win;
    end else begin
      space = SP_GLOBAL;  offset = addr;
    end
  end

  logic [2:0] amask;
  logic misal, atomic_like;
  always_comb begin
    case (size)
      2'd0:    amask = 3'b000;
      2'd1:    amask = 3'b001;
      2'd2:    amask = 3'b011;
      default: amask = 3'b111;
    endcase
  end
  assign misal       = |(addr[2:0] & amask);
  assign atomic_like = (op == OP_ATOM) || (op == OP_RED);

  always_comb begin
    if (misal) err = ERR_W'(ERR_MISALIGN);
    else if (atomic_like && space != SP_GLOBAL) err = ERR_W'(ERR_SPACE);
    else err = ERR_W'(ERR_NONE);
  end
endmodule

// File: rtl/gaw_rsp_stage.sv
module gaw_rsp_stage
  import gaw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int ERR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  space_e            d_space,
  input  logic [ADDR_W-1:0] d_offset,
  input  logic [ERR_W-1:0]  d_err,
  output logic              accept,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output space_e            rsp_space,
  output logic [ADDR_W-1:0] rsp_offset,
  output logic [ERR_W-1:0]  rsp_err
);
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_space  <= SP_GLOBAL;
      rsp_offset <= '0;
      rsp_err    <= '0;
    end else begin
      if (req_ready) rsp_valid <= req_valid;
      if (accept) begin
        rsp_space  <= d_space;
        rsp_offset <= d_offset;
        rsp_err    <= d_err;
      end
    end
  end
endmodule

// File: rtl/gaw_decoder.sv
module gaw_decoder
  import gaw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int BASE_W = 32,
  parameter int WIN_LOG2 = 24,
  parameter int CFG_AW = 12,
  parameter int ERR_W = 8,
  parameter logic [BASE_W-1:0] LOCAL_RST = 32'hFF00_0000,
  parameter logic [BASE_W-1:0] SHARED_RST = 32'hFE00_0000,
  localparam int TAG_W = BASE_W - WIN_LOG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_waddr,
  input  logic [BASE_W-1:0] cfg_wdata,
  input  logic [CFG_AW-1:0] cfg_raddr,
  output logic [BASE_W-1:0] cfg_rdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic              req_gfx,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_space,
  output logic [ADDR_W-1:0] rsp_offset,
  output logic [ERR_W-1:0]  rsp_err
);
  logic [TAG_W-1:0]  loc_tag, shr_tag;
  logic [ERR_W-1:0]  stat_code, d_err;
  logic              cfg_err, accept;
  space_e            d_space, q_space;
  logic [ADDR_W-1:0] d_offset;

  gaw_win_regs #(
    .BASE_W(BASE_W), .WIN_LOG2(WIN_LOG2), .CFG_AW(CFG_AW), .ERR_W(ERR_W),
    .LOCAL_RST(LOCAL_RST), .SHARED_RST(SHARED_RST)
  ) i_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .acc_valid(accept), .acc_err(d_err), .loc_tag(loc_tag), .shr_tag(shr_tag),
    .stat_code(stat_code), .cfg_err(cfg_err)
  );

  gaw_classify #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .WIN_LOG2(WIN_LOG2), .ERR_W(ERR_W)
  ) i_cls (
    .addr(req_addr), .op(req_op), .size(req_size), .gfx(req_gfx),
    .loc_tag(loc_tag), .shr_tag(shr_tag),
    .space(d_space), .offset(d_offset), .err(d_err)
  );

  gaw_rsp_stage #(.ADDR_W(ADDR_W), .ERR_W(ERR_W)) i_out (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .d_space(d_space), .d_offset(d_offset), .d_err(d_err), .accept(accept),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_space(q_space),
    .rsp_offset(rsp_offset), .rsp_err(rsp_err)
  );

  assign rsp_space = q_space;
endmodule

// File: rtl/gaw_decoder_chk.sv
module gaw_decoder_chk
  import gaw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int BASE_W = 32,
  parameter int WIN_LOG2 = 24,
  parameter int CFG_AW = 12,
  parameter int ERR_W = 8,
  localparam int TAG_W = BASE_W - WIN_LOG2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_space,
  input logic [ADDR_W-1:0] rsp_offset,
  input logic [ERR_W-1:0]  rsp_err,
  input logic              cfg_wr,
  input logic [CFG_AW-1:0] cfg_waddr,
  input logic [BASE_W-1:0] cfg_wdata,
  input logic [TAG_W-1:0]  loc_tag,
  input logic [TAG_W-1:0]  shr_tag,
  input logic [ERR_W-1:0]  stat_code
);
  logic bad_wr;
  assign bad_wr = cfg_wr && (cfg_wdata[WIN_LOG2-1:0] != '0);

  p_accept_r11: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> rsp_valid);
  p_stall_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |-> !req_ready);
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_space)
      && $stable(rsp_offset) && $stable(rsp_err));
  p_win_offset_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_space != 2'(SP_GLOBAL) |-> rsp_offset[ADDR_W-1:WIN_LOG2] == '0);
  p_space_err_r6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err == ERR_W'(ERR_SPACE) |-> rsp_space != 2'(SP_GLOBAL));
  p_loc_guard_r9: assert property (@(posedge clk) disable iff (rst)
    bad_wr && cfg_waddr == CFG_AW'(MTH_LOCAL) |=> $stable(loc_tag));
  p_shr_guard_r9: assert property (@(posedge clk) disable iff (rst)
    bad_wr && cfg_waddr == CFG_AW'(MTH_SHARED) |=> $stable(shr_tag));
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    stat_code != '0 && !(cfg_wr && cfg_waddr == CFG_AW'(MTH_STATUS)) |=> $stable(stat_code));
endmodule

bind gaw_decoder gaw_decoder_chk #(
  .ADDR_W(ADDR_W), .BASE_W(BASE_W), .WIN_LOG2(WIN_LOG2), .CFG_AW(CFG_AW), .ERR_W(ERR_W)
) i_gaw_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_space(rsp_space),
  .rsp_offset(rsp_offset), .rsp_err(rsp_err), .cfg_wr(cfg_wr),
  .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata), .loc_tag(loc_tag),
  .shr_tag(shr_tag), .stat_code(stat_code)
);

// File: tb/test_gaw_decoder.sv
`timescale 1ns/1ps
module test_gaw_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [11:0] cfg_waddr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [11:0] cfg_raddr = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic [2:0]  req_op = '0;
  logic [1:0]  req_size = '0;
  logic        req_gfx = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [1:0]  rsp_space;
  logic [63:0] rsp_offset;
  logic [7:0]  rsp_err;

  gaw_decoder i_gaw_decoder (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_waddr(cfg_waddr),
    .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_op(req_op), .req_size(req_size), .req_gfx(req_gfx),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_space(rsp_space),
    .rsp_offset(rsp_offset), .rsp_err(rsp_err)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [1:0]  space;
    logic [63:0] offset;
    logic [7:0]  err;
    string       tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  int ready_mode = 0;
  logic [31:0] m_loc = 32'hFF00_0000;
  logic [31:0] m_shr = 32'hFE00_0000;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic item_t model(input logic [63:0] a, input logic [2:0] op,
                                  input logic [1:0] sz, input logic g, input string tag);
    item_t it;
    logic lh, sh, mis;
    lh = (a[63:32] == 0) && (a[31:24] == m_loc[31:24]);
    sh = !g && (a[63:32] == 0) && (a[31:24] == m_shr[31:24]);
    if (op == 3'd5)      begin it.space = 2'd1; it.offset = a & 64'hFF_FFFF; end
    else if (op == 3'd6) begin it.space = 2'd2; it.offset = a & 64'hFF_FFFF; end
    else if (lh)         begin it.space = 2'd1; it.offset = a & 64'hFF_FFFF; end
    else if (sh)         begin it.space = 2'd2; it.offset = a & 64'hFF_FFFF; end
    else                 begin it.space = 2'd0; it.offset = a; end
    mis = (a & ((64'd1 << sz) - 64'd1)) != 0;
    if (mis) it.err = 8'h0F;
    else if ((op == 3'd2 || op == 3'd3) && it.space != 2'd0) it.err = 8'h10;
    else it.err = 8'h00;
    it.tag = tag;
    return it;
  endfunction

  task automatic send(input logic [63:0] a, input logic [2:0] op,
                      input logic [1:0] sz, input logic g, input string tag);
    item_t it;
    it = model(a, op, sz, g, tag);
    @(posedge clk); #1;
    req_addr = a; req_op = op; req_size = sz; req_gfx = g; req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    q.push_back(it);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_wr = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    if (d[23:0] == 0) begin
      if (a == 12'h77C) m_loc = d;
      if (a == 12'h214) m_shr = d;
    end
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    cfg_raddr = a;
    @(posedge clk);
    @(negedge clk);
    check(cfg_rdata == exp, tag, "cfg_rdata", 64'(cfg_rdata), 64'(exp));
  endtask

  // response consumer ready
  always begin
    @(posedge clk); #1;
    if (ready_mode == 1) rsp_ready = 1'b0;
    else rsp_ready = ($urandom_range(0, 3) != 0);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid && rsp_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R11", "unexpected response", rsp_offset, 64'd0);
      end else begin
        item_t e;
        e = q.pop_front();
        check(rsp_space == e.space, e.tag, "space", 64'(rsp_space), 64'(e.space));
        check(rsp_offset == e.offset, e.tag, "offset", rsp_offset, e.offset);
        check(rsp_err == e.err, e.tag, "err", 64'(rsp_err), 64'(e.err));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(rsp_valid == 1'b0, "R1", "rsp_valid", 64'(rsp_valid), 64'd0);
    check(req_ready == 1'b1, "R1", "req_ready", 64'(req_ready), 64'd1);
    rd(12'h77C, 32'hFF00_0000, "R1");
    rd(12'h214, 32'hFE00_0000, "R1");
    rd(12'h048, 32'h0, "R1");
    rd(12'h100, 32'h0, "R12");

    send(64'h0000_0000_FF00_0010, 3'd0, 2'd2, 1'b0, "R2");
    send(64'h0000_0000_FF00_0000, 3'd1, 2'd3, 1'b0, "R2");
    send(64'h0000_0000_FFFF_FFFC, 3'd0, 2'd2, 1'b0, "R2");
    send(64'h0000_0000_FEFF_FFFC, 3'd0, 2'd2, 1'b0, "R3");
    send(64'h0000_0000_FEFF_FFFC, 3'd0, 2'd2, 1'b1, "R3");
    send(64'h0000_0001_FF00_0010, 3'd0, 2'd2, 1'b0, "R4");
    send(64'h0000_0000_0000_1000, 3'd1, 2'd3, 1'b0, "R4");
    send(64'h0000_0000_FD00_0000, 3'd0, 2'd0, 1'b0, "R4");
    drain();

    send(64'h0000_0000_FF00_0020, 3'd2, 2'd2, 1'b0, "R6");
    send(64'h0000_0000_FF00_0021, 3'd0, 2'd2, 1'b0, "R8");
    drain();
    rd(12'h048, 32'h10, "R10");
    wr(12'h048, 32'h0);
    rd(12'h048, 32'h0, "R10");

    send(64'h0000_0000_0000_2000, 3'd2, 2'd2, 1'b0, "R6");
    send(64'h0000_0000_FE00_0040, 3'd3, 2'd2, 1'b1, "R6");
    send(64'h0000_0000_FE00_0040, 3'd3, 2'd2, 1'b0, "R6");
    send(64'h0000_0000_FF00_0100, 3'd1, 2'd2, 1'b0, "R6");
    send(64'h0000_0000_FE00_0100, 3'd4, 2'd0, 1'b0, "R6");
    send(64'h0000_0000_FF00_0024, 3'd2, 2'd3, 1'b0, "R8");
    send(64'h0000_0000_0012_3456, 3'd5, 2'd1, 1'b0, "R7");
    send(64'hABCD_0000_0012_3458, 3'd6, 2'd2, 1'b1, "R7");
    drain();
    rd(12'h048, 32'h10, "R10");
    wr(12'h048, 32'h0);

    wr(12'h77C, 32'h4000_0001);
    rd(12'h77C, 32'hFF00_0000, "R9");
    rd(12'h048, 32'h100, "R9");
    wr(12'h77C, 32'h4000_0000);
    rd(12'h048, 32'h100, "R9");
    rd(12'h77C, 32'h4000_0000, "R12");
    wr(12'h048, 32'h0);
    rd(12'h048, 32'h0, "R10");
    send(64'h0000_0000_4000_0008, 3'd0, 2'd3, 1'b0, "R2");
    wr(12'h214, 32'h4000_0000);
    rd(12'h214, 32'h4000_0000, "R12");
    send(64'h0000_0000_4000_0008, 3'd0, 2'd3, 1'b0, "R5");
    send(64'h0000_0000_4000_0010, 3'd3, 2'd2, 1'b0, "R5");
    drain();
    rd(12'h048, 32'h10, "R10");
    wr(12'h048, 32'h0);

    // stall: consumer held off
    ready_mode = 1;
    repeat (2) @(posedge clk);
    send(64'h0000_0000_0000_3000, 3'd0, 2'd2, 1'b0, "R11");
    @(negedge clk);
    check(rsp_valid == 1'b1, "R11", "rsp_valid after accept", 64'(rsp_valid), 64'd1);
    check(req_ready == 1'b0, "R11", "req_ready under stall", 64'(req_ready), 64'd0);
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b1 && rsp_offset == 64'h3000, "R11", "held offset",
          rsp_offset, 64'h3000);
    ready_mode = 0;
    for (int i = 0; i < 8; i++)
      send(64'h0000_0000_FF00_0000 + 64'(i * 8), 3'(i % 5), 2'd3, 1'(i & 1), "R11");
    drain();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule